// File: doc/BRIEF.md
# Three-Phase Dead-Time Inserter

This block sits between the pulse-width generator of a three-phase inverter and its gate drivers. For every phase it receives a raw request for the upper and the lower transistor and gives out gated drive signals. Both are in active-on form: 1 means the transistor is on. When a phase is told that a switching event has happened, it holds both of its drive signals off for a programmed number of counts. The transistor that is switching off has already gone off, so the one switching on cannot start to conduct while the other still does. When the count runs out, the drives follow the requests again.

Each phase has its own down-counter. All three counters load from one shared reload value. The counters step on every clock, or on a divided tick from a shared prescaler. A select input chooses which per-phase event starts a phase's counter: the rising edge of the output shift register or the falling edge of the one-shot pulse. In sawtooth-modulation mode, a transfer strobe also starts the counters of all three phases. A bypass input turns dead time off completely, and the requests then pass straight through. Level conversion for the pins is not part of this block.

Top module: `three_phase_deadtime`

## Requirements
- R1: While rst_n is low, all six drive outputs are 0, whatever the requests are.
- R2: While dt_off is 1, each drive output equals its request in the same cycle, and triggers have no effect. Raising dt_off clears any running count, so after dt_off returns to 0 no leftover hold-off remains.
- R3: With trig_sel = 1, only shreg_rise[i] starts the counter of phase i. With trig_sel = 0, only oneshot_fall[i] starts it. The strobe that is not selected has no effect on the outputs.
- R4: With saw_mode = 1, a pulse on xfer_strobe starts the counters of all three phases. With saw_mode = 0, xfer_strobe has no effect.
- R5: With div_sel = 0 and a reload value N > 0, a trigger in cycle T holds both drives of that phase at 0 in cycles T through T+N. From cycle T+N+1 onward, the drives equal the requests.
- R6: With div_sel = 1, the counter steps once every DIV clocks, on a free-running prescaler. For N > 0, the number of held-off cycles L satisfies (N-1)*DIV+2 <= L <= N*DIV+1.
- R7: A reload value of 0 inserts no hold-off, even with dead time enabled.
- R8: A trigger on one phase leaves the drive outputs of the other two phases unchanged.
- R9: A new trigger during a running count reloads the counter. The hold-off then lasts N+1 cycles counted from the new trigger.
- R10: The reload value is taken at the trigger. Changing reload during a running count does not change that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dt_off | input | 1 | 1 = no dead time, requests pass through |
| div_sel | input | 1 | Count source: 0 = every clock, 1 = divided tick |
| trig_sel | input | 1 | Trigger source: 1 = shift-register rise, 0 = one-shot fall |
| saw_mode | input | 1 | Sawtooth mode: transfer strobe also triggers |
| xfer_strobe | input | 1 | Transfer trigger pulse |
| reload | input | DT_W | Shared dead-time reload value |
| req_hi | input | NPH | Raw upper-side requests, one bit per phase |
| req_lo | input | NPH | Raw lower-side requests, one bit per phase |
| shreg_rise | input | NPH | Output shift register rising-edge strobes |
| oneshot_fall | input | NPH | One-shot pulse falling-edge strobes |
| drv_hi | output | NPH | Gated upper-side drives, active-on |
| drv_lo | output | NPH | Gated lower-side drives, active-on |

## Verification
The drive outputs are combinational from the registered counters and the current inputs. The hold-off therefore starts in the trigger cycle itself, and with the undivided source it releases exactly N+1 cycles later. The bench changes every input just after a falling edge and reads the outputs 1 ns later, in that same cycle. It then steps one clock per sample, so that cycle k after the trigger is compared against the expectation for k. With the divided source the prescaler phase is not tied to the trigger, so the bench counts the held-off cycles and checks the count against the window of one tick given in R6.

// File: rtl/dt_pkg.sv
package dt_pkg;

  typedef enum logic {
    TRIG_ONESHOT = 1'b0,
    TRIG_SHIFT   = 1'b1
  } trig_src_e;

  // Start condition of one phase's dead-time counter.
  function automatic logic pick_trigger(input trig_src_e src,
                                        input logic      shr,
                                        input logic      osf,
                                        input logic      saw,
                                        input logic      xfer);
    logic own;
    own = (src == TRIG_SHIFT) ? shr : osf;
    return own | (saw & xfer);
  endfunction

endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_sel,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc;
  logic          wrap;

  assign wrap = (pc == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    pc <= '0;
    else if (wrap) pc <= '0;
    else           pc <= pc + 1'b1;
  end

  assign tick = div_sel ? wrap : 1'b1;

  generate
    if (DIV > 1) begin : g_chk
      // R6: divided ticks never arrive on back-to-back cycles
      p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel && tick) |=> (!div_sel || !tick));
    end
  endgenerate

endmodule

// File: rtl/dt_phase.sv
module dt_phase #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dt_off,
  input  logic            tick,
  input  logic            trig,
  input  logic [DT_W-1:0] reload,
  input  logic            req_hi,
  input  logic            req_lo,
  output logic            drv_hi,
  output logic            drv_lo
);
  logic [DT_W-1:0] cnt;
  logic            busy;
  logic            running;

  function automatic logic [DT_W-1:0] next_count(input logic [DT_W-1:0] c,
                                                 input logic            tk);
    return (c != '0 && tk) ? c - 1'b1 : c;
  endfunction

  assign running = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (dt_off) cnt <= '0;
    else if (trig)   cnt <= reload;
    else             cnt <= next_count(cnt, tick);
  end

  // Hold-off starts in the trigger cycle, before the counter is loaded.
  assign busy   = !dt_off && (running || (trig && reload != '0));
  assign drv_hi = rst_n && req_hi && !busy;
  assign drv_lo = rst_n && req_lo && !busy;

  // R5 / R10: a trigger loads the reload value present at that edge
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dt_off && trig) |=> (cnt == $past(reload)));

  // R6: a running count moves by exactly one per tick
  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dt_off && !trig && running) |=> (cnt == $past(cnt) - DT_W'($past(tick))));

  // R5: the last tick releases the drives unless a new trigger arrives
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dt_off && !trig && cnt == DT_W'(1) && tick) |=>
      (trig || (drv_hi == req_hi && drv_lo == req_lo)));

  // R2: bypass passes requests straight through
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dt_off |-> (drv_hi == req_hi && drv_lo == req_lo));

  // R2: bypass clears the counter
  p_bypass_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dt_off |=> (cnt == '0));

  // R7: zero reload on an idle phase gives no hold-off
  p_zero_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && reload == '0 && !running) |-> (drv_hi == req_hi && drv_lo == req_lo));

endmodule

// File: rtl/three_phase_deadtime.sv
module three_phase_deadtime #(
  parameter int NPH  = 3,
  parameter int DT_W = 8,
  parameter int DIV  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dt_off,
  input  logic            div_sel,
  input  logic            trig_sel,
  input  logic            saw_mode,
  input  logic            xfer_strobe,
  input  logic [DT_W-1:0] reload,
  input  logic [NPH-1:0]  req_hi,
  input  logic [NPH-1:0]  req_lo,
  input  logic [NPH-1:0]  shreg_rise,
  input  logic [NPH-1:0]  oneshot_fall,
  output logic [NPH-1:0]  drv_hi,
  output logic [NPH-1:0]  drv_lo
);
  import dt_pkg::*;

  logic           tick;
  logic [NPH-1:0] trig;
  trig_src_e      src;

  assign src = trig_src_e'(trig_sel);

  dt_prescaler #(.DIV(DIV)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .tick    (tick)
  );

  generate
    for (genvar i = 0; i < NPH; i++) begin : g_ph
      assign trig[i] = pick_trigger(src, shreg_rise[i], oneshot_fall[i],
                                    saw_mode, xfer_strobe);
      dt_phase #(.DT_W(DT_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .dt_off (dt_off),
        .tick   (tick),
        .trig   (trig[i]),
        .reload (reload),
        .req_hi (req_hi[i]),
        .req_lo (req_lo[i]),
        .drv_hi (drv_hi[i]),
        .drv_lo (drv_lo[i])
      );
    end
  endgenerate

  // R1: outputs are off throughout reset
  always_comb begin
    if (!rst_n) begin
      a_reset_off_r1: assert (drv_hi == '0 && drv_lo == '0);
    end
  end

  // R4: a sawtooth transfer holds every phase off at once
  p_saw_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (saw_mode && xfer_strobe && !dt_off && reload != '0) |->
      (drv_hi == '0 && drv_lo == '0));

endmodule

// File: tb/test_three_phase_deadtime.sv
module test_three_phase_deadtime;
  localparam int NPH  = 3;
  localparam int DT_W = 8;
  localparam int DIVB = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            dt_off, div_sel, trig_sel, saw_mode, xfer_strobe;
  logic [DT_W-1:0] reload;
  logic [NPH-1:0]  req_hi, req_lo, shreg_rise, oneshot_fall;
  logic [NPH-1:0]  drv_hi, drv_lo;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  three_phase_deadtime #(.NPH(NPH), .DT_W(DT_W), .DIV(DIVB)) i_three_phase_deadtime (
    .clk(clk), .rst_n(rst_n), .dt_off(dt_off), .div_sel(div_sel),
    .trig_sel(trig_sel), .saw_mode(saw_mode), .xfer_strobe(xfer_strobe),
    .reload(reload), .req_hi(req_hi), .req_lo(req_lo),
    .shreg_rise(shreg_rise), .oneshot_fall(oneshot_fall),
    .drv_hi(drv_hi), .drv_lo(drv_lo));

  task automatic chk_out(input logic [NPH-1:0] mask, input string tag);
    logic [2*NPH-1:0] exp_v, act_v;
    exp_v = {req_hi & ~mask, req_lo & ~mask};
    act_v = {drv_hi, drv_lo};
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: drv {hi,lo} got %b expected %b at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic pulse(input int ph, input int kind);
    case (kind)
      0: oneshot_fall[ph] = 1'b1;
      1: shreg_rise[ph]   = 1'b1;
      default: xfer_strobe = 1'b1;
    endcase
  endtask

  task automatic clr_strobes();
    oneshot_fall = '0; shreg_rise = '0; xfer_strobe = 1'b0;
  endtask

  // kind 0: one-shot (trig_sel 0), 1: shift rise (trig_sel 1), 2: sawtooth transfer
  task automatic shot(input int ph, input int kind, input int r, input string tag);
    logic [NPH-1:0] m;
    m = (kind == 2) ? {NPH{1'b1}} : NPH'(1 << ph);
    trig_sel = (kind == 1);
    saw_mode = (kind == 2);
    reload   = DT_W'(r);
    @(negedge clk);
    req_hi[ph] = ~req_hi[ph];
    req_lo[ph] = ~req_hi[ph];
    pulse(ph, kind);
    #1 chk_out((r > 0) ? m : '0, tag);
    for (int k = 1; k <= r + 2; k++) begin
      @(negedge clk);
      clr_strobes();
      #1 chk_out((k <= r) ? m : '0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): run reached %0d cycles, expected to finish earlier", 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dt_off = 1'b0; div_sel = 1'b0; trig_sel = 1'b0;
    saw_mode = 1'b0; xfer_strobe = 1'b0; reload = '0;
    req_hi = 3'b111; req_lo = 3'b111; shreg_rise = '0; oneshot_fall = '0;

    // R1: reset holds every drive off
    repeat (2) @(negedge clk);
    #1 chk_out(3'b111, "R1 reset");
    @(negedge clk);
    req_hi = 3'b101; req_lo = 3'b010;
    #1 chk_out(3'b111, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk_out('0, "R5 idle after reset");

    // R5 / R7 / R8 / R3: sweep reload, phases and both trigger sources
    for (int ph = 0; ph < NPH; ph++)
      for (int kind = 0; kind < 2; kind++)
        for (int r = 0; r <= 12; r++)
          shot(ph, kind, r, (r == 0) ? "R7 zero reload" : "R5 R8 R3 hold-off");
    shot(1, 0, 255, "R5 full-scale reload");

    // R4: sawtooth transfer triggers all phases
    for (int r = 0; r <= 6; r++) shot(2, 2, r, "R4 sawtooth transfer");

    // R4: transfer ignored outside sawtooth mode
    saw_mode = 1'b0; reload = 8'd5;
    @(negedge clk); xfer_strobe = 1'b1;
    #1 chk_out('0, "R4 transfer ignored");
    @(negedge clk); clr_strobes();
    #1 chk_out('0, "R4 transfer ignored");

    // R3: the strobe not selected has no effect
    trig_sel = 1'b1;
    @(negedge clk); oneshot_fall = 3'b111;
    #1 chk_out('0, "R3 one-shot ignored");
    @(negedge clk); clr_strobes();
    #1 chk_out('0, "R3 one-shot ignored");
    trig_sel = 1'b0;
    @(negedge clk); shreg_rise = 3'b111;
    #1 chk_out('0, "R3 shift rise ignored");
    @(negedge clk); clr_strobes();
    #1 chk_out('0, "R3 shift rise ignored");

    // R2: raising dt_off mid-count clears it
    trig_sel = 1'b0; reload = 8'd20;
    @(negedge clk); oneshot_fall[1] = 1'b1;
    #1 chk_out(3'b010, "R2 count running");
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); clr_strobes();
      if (k == 3) dt_off = 1'b1;
      if (k == 4) dt_off = 1'b0;
      #1 chk_out((k < 3) ? 3'b010 : 3'b000, "R2 bypass clears count");
    end
    // R2: triggers ignored while bypassed
    dt_off = 1'b1; reload = 8'd10;
    @(negedge clk); oneshot_fall = 3'b111; req_hi = ~req_hi; req_lo = ~req_lo;
    #1 chk_out('0, "R2 bypass pass-through");
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); clr_strobes();
      #1 chk_out('0, "R2 bypass pass-through");
    end
    dt_off = 1'b0;

    // R9: retrigger at k = 5 extends the hold-off to k = 15
    reload = 8'd10;
    @(negedge clk); oneshot_fall[2] = 1'b1;
    #1 chk_out(3'b100, "R9 retrigger");
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk); clr_strobes();
      if (k == 5) oneshot_fall[2] = 1'b1;
      #1 chk_out((k <= 15) ? 3'b100 : 3'b000, "R9 retrigger");
    end

    // R10: reload change during a count is not picked up
    reload = 8'd10;
    @(negedge clk); oneshot_fall[0] = 1'b1;
    #1 chk_out(3'b001, "R10 reload sampled at trigger");
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk); clr_strobes();
      if (k == 1) reload = 8'd2;
      #1 chk_out((k <= 10) ? 3'b001 : 3'b000, "R10 reload sampled at trigger");
    end

    // R6: divided count source, measured hold-off length
    div_sel = 1'b1; trig_sel = 1'b0;
    for (int r = 0; r <= 6; r++) begin
      int len, lo_b, hi_b;
      reload = DT_W'(r);
      len = 0;
      @(negedge clk); oneshot_fall[0] = 1'b1;
      #1 if (drv_hi[0] !== req_hi[0] || drv_lo[0] !== req_lo[0]) len++;
      for (int k = 1; k <= r * DIVB + 6; k++) begin
        @(negedge clk); clr_strobes();
        #1 if (drv_hi[0] !== req_hi[0] || drv_lo[0] !== req_lo[0]) len++;
      end
      lo_b = (r == 0) ? 0 : (r - 1) * DIVB + 2;
      hi_b = (r == 0) ? 0 : r * DIVB + 1;
      n_chk++;
      if (len < lo_b || len > hi_b) begin
        n_fail++;
        $display("FAIL R6 divided source: held-off cycles got %0d expected %0d..%0d", len, lo_b, hi_b);
      end
    end
    div_sel = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule